// File: doc/BRIEF.md
# UART Byte Queue Engine

This block moves characters between a UART and a 256-byte on-chip RAM window without the CPU handling each byte. It has two independent channels. The transmit channel fetches the next byte from RAM and hands it to the UART transmit buffer each time the UART reports that its transmitter is free. The receive channel stores each byte the UART delivers into RAM. Each channel keeps a byte pointer and a remaining-byte count. The pointer advances and the count falls by one for every byte moved. When the count reaches zero the channel stops and raises its done flag.

Both channels share one synchronous RAM port through an address multiplexer. When both want the port in the same cycle, the receive channel goes first, so no incoming byte is lost. The receive channel also compares every stored byte with a programmable match value and flags any hit. Software programs the block through a small 16-bit register bus. The control word holds a receive byte and a transmit byte, and either lane can be written alone. Pointer and count values read while a channel runs are only a snapshot. Software halts a channel before it relies on them.

Top module: `uart_queue_dma`

## Requirements
- R1: After reset every register (offsets 0 to 5) reads zero, and irq_o, ram_we_o and tx_load_o are low.
- R2: While the receive channel is enabled and its count (offset 4) is nonzero, a cycle with rx_valid_i high writes rx_data_i into RAM at the receive pointer (offset 3) in that same cycle with ram_we_o high. On the next edge the pointer rises by one and the count falls by one.
- R3: While the transmit channel is enabled and its count (offset 2) is nonzero, a tx_free_i pulse causes a RAM read at the transmit pointer (offset 1) in the following cycle. RAM data arrives one cycle after its address. tx_load_o is high for one cycle one cycle after that read, with tx_data_o carrying the RAM byte. The pointer rises by one and the count falls by one.
- R4: When a receive write and a pending transmit read fall in the same cycle, the receive write is done first. The transmit read follows one cycle later, and its tx_load_o comes two cycles after the receive write.
- R5: One cycle after a channel's count reaches zero, its enable bit (bit 0 of its control lane) clears and its done flag (bit 4) sets. Further strobes for that channel move no byte.
- R6: A received byte equal to the match register (offset 5) sets the match flag (bit 5 of the low lane of offset 0). A byte that differs leaves the flag unchanged.
- R7: Writing a one to a flag bit clears that flag. Writing zero to it leaves the flag as it was.
- R8: irq_o is high exactly when some flag is set and its enable bit is set. The done flag is enabled by bit 1 of its lane, and the match flag by bit 2 of the low lane.
- R9: Offset 0 holds receive control in bits 7:0 and transmit control in bits 15:8. reg_be_i bit 0 and bit 1 gate each byte lane independently. Pointer, count and match registers take byte lane 0. Bit 3 of each control lane reads one while that channel is busy.
- R10: Pointers wrap from FFh to 00h, so a buffer may straddle the top of the RAM window.
- R11: A channel whose enable bit is clear ignores its UART strobe: it makes no RAM write and no transmit load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_en_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Register write when high |
| reg_addr_i | input | 3 | Register offset |
| reg_be_i | input | 2 | Byte-lane enables |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational on reg_addr_i) |
| tx_free_i | input | 1 | UART transmitter free pulse |
| tx_load_o | output | 1 | Load pulse into the UART transmit buffer |
| tx_data_o | output | 8 | Byte for the UART transmit buffer |
| rx_valid_i | input | 1 | UART received-byte pulse |
| rx_data_i | input | 8 | Received byte |
| ram_addr_o | output | 8 | RAM address |
| ram_we_o | output | 1 | RAM write enable |
| ram_wdata_o | output | 8 | RAM write data |
| ram_rdata_i | input | 8 | RAM read data, one cycle after the address |
| irq_o | output | 1 | Combined interrupt |

## Verification
The receive path is driven with a table of bytes. Some bytes equal the match value and some do not, and the buffer starts just below the top of the window. Together they show the store address, the wrap and the compare agreeing or disagreeing byte by byte. The transmit path is driven with single free pulses over a preloaded buffer, which checks the one-cycle read latency and the byte order. A transmit request that meets a receive strobe in the same cycle separates the intended ordering from a lost or overwritten byte. Strobes sent to disabled or exhausted channels, and partial control-word writes, show that nothing moves when it should not.

// File: rtl/uq_pkg.sv
package uq_pkg;
  localparam int CH_RX  = 0;
  localparam int CH_TX  = 1;
  localparam int NUM_CH = 2;

  typedef enum logic [2:0] {
    REG_CTRL   = 3'd0,
    REG_TX_PTR = 3'd1,
    REG_TX_CNT = 3'd2,
    REG_RX_PTR = 3'd3,
    REG_RX_CNT = 3'd4,
    REG_MATCH  = 3'd5
  } reg_idx_e;

  // bit positions inside one control lane
  localparam int CTL_EN       = 0;
  localparam int CTL_DONE_IE  = 1;
  localparam int CTL_MATCH_IE = 2;
  localparam int CTL_BUSY     = 3;
  localparam int CTL_DONE     = 4;
  localparam int CTL_MATCH    = 5;
endpackage

// File: rtl/uq_channel.sv
module uq_channel #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctl_we_i,
  input  logic          ctl_en_i,
  input  logic          ctl_ie_i,
  input  logic          ctl_clr_i,
  input  logic          ptr_we_i,
  input  logic          cnt_we_i,
  input  logic [AW-1:0] cfg_wdata_i,
  input  logic          step_i,
  output logic          en_o,
  output logic          ie_o,
  output logic          done_o,
  output logic          active_o,
  output logic [AW-1:0] ptr_o,
  output logic [AW-1:0] cnt_o
);
  logic cnt_zero, finish;

  assign cnt_zero = (cnt_o == '0);
  assign finish   = en_o & cnt_zero;
  assign active_o = en_o & ~cnt_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      ie_o   <= 1'b0;
      done_o <= 1'b0;
      ptr_o  <= '0;
      cnt_o  <= '0;
    end else begin
      if (ctl_we_i) begin
        en_o <= ctl_en_i;
        ie_o <= ctl_ie_i;
      end else if (finish) begin
        en_o <= 1'b0;
      end
      // set beats clear
      if (finish)                      done_o <= 1'b1;
      else if (ctl_we_i && ctl_clr_i)  done_o <= 1'b0;
      if (ptr_we_i)    ptr_o <= cfg_wdata_i;
      else if (step_i) ptr_o <= ptr_o + 1'b1;
      if (cnt_we_i)    cnt_o <= cfg_wdata_i;
      else if (step_i) cnt_o <= cnt_o - 1'b1;
    end
  end
endmodule

// File: rtl/uq_match.sv
module uq_match #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          val_we_i,
  input  logic [DW-1:0] val_wdata_i,
  input  logic          ctl_we_i,
  input  logic          ctl_ie_i,
  input  logic          ctl_clr_i,
  input  logic          rx_step_i,
  input  logic [DW-1:0] rx_data_i,
  output logic [DW-1:0] val_o,
  output logic          ie_o,
  output logic          flag_o
);
  logic hit;
  assign hit = rx_step_i & (rx_data_i == val_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_o  <= '0;
      ie_o   <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      if (val_we_i) val_o <= val_wdata_i;
      if (ctl_we_i) ie_o  <= ctl_ie_i;
      if (hit)                        flag_o <= 1'b1;
      else if (ctl_we_i && ctl_clr_i) flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uq_ram_arb.sv
module uq_ram_arb #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_active_i,
  input  logic [AW-1:0] rx_ptr_i,
  input  logic          tx_free_i,
  input  logic          tx_active_i,
  input  logic [AW-1:0] tx_ptr_i,
  input  logic [DW-1:0] ram_rdata_i,
  output logic          rx_step_o,
  output logic          tx_step_o,
  output logic [AW-1:0] ram_addr_o,
  output logic          ram_we_o,
  output logic [DW-1:0] ram_wdata_o,
  output logic          tx_load_o,
  output logic [DW-1:0] tx_data_o
);
  logic tx_pend_q, load_q;

  // receive owns the port whenever it strobes; transmit waits
  assign rx_step_o   = rx_valid_i & rx_active_i;
  assign tx_step_o   = tx_pend_q & tx_active_i & ~rx_step_o;
  assign ram_addr_o  = rx_step_o ? rx_ptr_i : tx_ptr_i;
  assign ram_we_o    = rx_step_o;
  assign ram_wdata_o = rx_data_i;
  assign tx_load_o   = load_q;
  assign tx_data_o   = ram_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_pend_q <= 1'b0;
      load_q    <= 1'b0;
    end else begin
      if (!tx_active_i)   tx_pend_q <= 1'b0;
      else if (tx_step_o) tx_pend_q <= 1'b0;
      else if (tx_free_i) tx_pend_q <= 1'b1;
      load_q <= tx_step_o;
    end
  end
endmodule

// File: rtl/uart_queue_dma.sv
module uart_queue_dma
  import uq_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_en_i,
  input  logic            reg_we_i,
  input  logic [2:0]      reg_addr_i,
  input  logic [1:0]      reg_be_i,
  input  logic [2*DW-1:0] reg_wdata_i,
  output logic [2*DW-1:0] reg_rdata_o,
  input  logic            tx_free_i,
  output logic            tx_load_o,
  output logic [DW-1:0]   tx_data_o,
  input  logic            rx_valid_i,
  input  logic [DW-1:0]   rx_data_i,
  output logic [AW-1:0]   ram_addr_o,
  output logic            ram_we_o,
  output logic [DW-1:0]   ram_wdata_o,
  input  logic [DW-1:0]   ram_rdata_i,
  output logic            irq_o
);
  localparam int BW = 2 * DW;

  reg_idx_e sel;
  logic     wr;
  logic [NUM_CH-1:0] ctl_we, ptr_we, cnt_we, ch_step;
  logic [NUM_CH-1:0] ch_en, ch_ie, ch_done, ch_active;
  logic [DW-1:0]     ctl_wr [NUM_CH];
  logic [DW-1:0]     ctl_rd [NUM_CH];
  logic [AW-1:0]     ch_ptr [NUM_CH];
  logic [AW-1:0]     ch_cnt [NUM_CH];
  logic [DW-1:0]     match_val;
  logic              match_ie, match_flag;
  logic              unused_wdata;

  assign sel = reg_idx_e'(reg_addr_i);
  assign wr  = reg_en_i & reg_we_i;

  assign ctl_wr[CH_RX] = reg_wdata_i[DW-1:0];
  assign ctl_wr[CH_TX] = reg_wdata_i[BW-1:DW];
  assign ctl_we[CH_RX] = wr & (sel == REG_CTRL) & reg_be_i[0];
  assign ctl_we[CH_TX] = wr & (sel == REG_CTRL) & reg_be_i[1];
  assign ptr_we[CH_RX] = wr & (sel == REG_RX_PTR) & reg_be_i[0];
  assign ptr_we[CH_TX] = wr & (sel == REG_TX_PTR) & reg_be_i[0];
  assign cnt_we[CH_RX] = wr & (sel == REG_RX_CNT) & reg_be_i[0];
  assign cnt_we[CH_TX] = wr & (sel == REG_TX_CNT) & reg_be_i[0];
  assign unused_wdata  = ^{reg_wdata_i};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    uq_channel #(.AW(AW)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ctl_we_i   (ctl_we[c]),
      .ctl_en_i   (ctl_wr[c][CTL_EN]),
      .ctl_ie_i   (ctl_wr[c][CTL_DONE_IE]),
      .ctl_clr_i  (ctl_wr[c][CTL_DONE]),
      .ptr_we_i   (ptr_we[c]),
      .cnt_we_i   (cnt_we[c]),
      .cfg_wdata_i(reg_wdata_i[AW-1:0]),
      .step_i     (ch_step[c]),
      .en_o       (ch_en[c]),
      .ie_o       (ch_ie[c]),
      .done_o     (ch_done[c]),
      .active_o   (ch_active[c]),
      .ptr_o      (ch_ptr[c]),
      .cnt_o      (ch_cnt[c])
    );

    always_comb begin
      ctl_rd[c]              = '0;
      ctl_rd[c][CTL_EN]      = ch_en[c];
      ctl_rd[c][CTL_DONE_IE] = ch_ie[c];
      ctl_rd[c][CTL_BUSY]    = ch_active[c];
      ctl_rd[c][CTL_DONE]    = ch_done[c];
      if (c == CH_RX) begin
        ctl_rd[c][CTL_MATCH_IE] = match_ie;
        ctl_rd[c][CTL_MATCH]    = match_flag;
      end
    end
  end

  uq_match #(.DW(DW)) u_match (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .val_we_i   (wr & (sel == REG_MATCH) & reg_be_i[0]),
    .val_wdata_i(reg_wdata_i[DW-1:0]),
    .ctl_we_i   (ctl_we[CH_RX]),
    .ctl_ie_i   (ctl_wr[CH_RX][CTL_MATCH_IE]),
    .ctl_clr_i  (ctl_wr[CH_RX][CTL_MATCH]),
    .rx_step_i  (ch_step[CH_RX]),
    .rx_data_i  (rx_data_i),
    .val_o      (match_val),
    .ie_o       (match_ie),
    .flag_o     (match_flag)
  );

  uq_ram_arb #(.AW(AW), .DW(DW)) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_valid_i (rx_valid_i),
    .rx_data_i  (rx_data_i),
    .rx_active_i(ch_active[CH_RX]),
    .rx_ptr_i   (ch_ptr[CH_RX]),
    .tx_free_i  (tx_free_i),
    .tx_active_i(ch_active[CH_TX]),
    .tx_ptr_i   (ch_ptr[CH_TX]),
    .ram_rdata_i(ram_rdata_i),
    .rx_step_o  (ch_step[CH_RX]),
    .tx_step_o  (ch_step[CH_TX]),
    .ram_addr_o (ram_addr_o),
    .ram_we_o   (ram_we_o),
    .ram_wdata_o(ram_wdata_o),
    .tx_load_o  (tx_load_o),
    .tx_data_o  (tx_data_o)
  );

  always_comb begin
    unique case (sel)
      REG_CTRL:   reg_rdata_o = {ctl_rd[CH_TX], ctl_rd[CH_RX]};
      REG_TX_PTR: reg_rdata_o = BW'(ch_ptr[CH_TX]);
      REG_TX_CNT: reg_rdata_o = BW'(ch_cnt[CH_TX]);
      REG_RX_PTR: reg_rdata_o = BW'(ch_ptr[CH_RX]);
      REG_RX_CNT: reg_rdata_o = BW'(ch_cnt[CH_RX]);
      REG_MATCH:  reg_rdata_o = BW'(match_val);
      default:    reg_rdata_o = '0;
    endcase
  end

  assign irq_o = (|(ch_done & ch_ie)) | (match_flag & match_ie);

  // named views for the bound checker
  logic [AW-1:0] rx_cnt;
  logic          rx_en, tx_en, rx_done, tx_done;
  assign rx_cnt  = ch_cnt[CH_RX];
  assign rx_en   = ch_en[CH_RX];
  assign tx_en   = ch_en[CH_TX];
  assign rx_done = ch_done[CH_RX];
  assign tx_done = ch_done[CH_TX];
endmodule

// File: rtl/uq_checker.sv
module uq_checker #(
  parameter int AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_en_i,
  input logic          reg_we_i,
  input logic [2:0]    reg_addr_i,
  input logic [1:0]    reg_be_i,
  input logic          rx_valid_i,
  input logic          ram_we_o,
  input logic          tx_load_o,
  input logic          irq_o,
  input logic [AW-1:0] rx_cnt,
  input logic          rx_en,
  input logic          tx_en,
  input logic          rx_done,
  input logic          tx_done,
  input logic          match_flag
);
  logic rx_cnt_wr;
  assign rx_cnt_wr = reg_en_i & reg_we_i & (reg_addr_i == 3'd4) & reg_be_i[0];

  assert_rx_write_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> rx_valid_i);

  assert_rx_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_o && !rx_cnt_wr) |=> (rx_cnt == AW'($past(rx_cnt) - 1'b1)));

  assert_tx_yields_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |=> !tx_load_o);

  assert_load_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_o |=> !tx_load_o);

  assert_tx_done_stops_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_done) |-> !tx_en);

  assert_rx_done_stops_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_done) |-> !rx_en);

  assert_irq_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (rx_done || tx_done || match_flag));

  assert_idle_no_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en |-> !ram_we_o);
endmodule

bind uart_queue_dma uq_checker #(.AW(AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .reg_en_i  (reg_en_i),
  .reg_we_i  (reg_we_i),
  .reg_addr_i(reg_addr_i),
  .reg_be_i  (reg_be_i),
  .rx_valid_i(rx_valid_i),
  .ram_we_o  (ram_we_o),
  .tx_load_o (tx_load_o),
  .irq_o     (irq_o),
  .rx_cnt    (rx_cnt),
  .rx_en     (rx_en),
  .tx_en     (tx_en),
  .rx_done   (rx_done),
  .tx_done   (tx_done),
  .match_flag(match_flag)
);

// File: tb/uart_queue_dma_bench.sv
`timescale 1ns/1ps
module uart_queue_dma_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_en = 1'b0, reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [1:0]  reg_be = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic        tx_free = 1'b0, tx_load;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic [7:0]  ram_addr, ram_wdata, ram_rdata;
  logic        ram_we, irq;

  logic [7:0]  mem [256];
  int          n_chk = 0, n_fail = 0;
  int          cyc = 0, wr_count = 0, tx_count = 0, wr_cyc = 0, tx_cyc = 0;
  logic [7:0]  last_tx = '0;

  always #10 clk = ~clk;

  uart_queue_dma u_uart_queue_dma (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_en_i(reg_en), .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_be_i(reg_be),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .tx_free_i(tx_free), .tx_load_o(tx_load), .tx_data_o(tx_data),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .ram_addr_o(ram_addr), .ram_we_o(ram_we), .ram_wdata_o(ram_wdata),
    .ram_rdata_i(ram_rdata), .irq_o(irq)
  );

  // RAM model and strobe monitor
  always @(posedge clk) begin
    if (ram_we) begin
      mem[ram_addr] <= ram_wdata;
      wr_count <= wr_count + 1;
      wr_cyc <= cyc;
    end
    ram_rdata <= mem[ram_addr];
    if (tx_load) begin
      tx_count <= tx_count + 1;
      last_tx <= tx_data;
      tx_cyc <= cyc;
    end
    cyc <= cyc + 1;
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_be = be; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0; reg_be = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rx_send(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic tx_pulse();
    @(negedge clk);
    tx_free = 1'b1;
    @(negedge clk);
    tx_free = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // {expected match, byte}
  localparam logic [8:0] VEC [6] = '{9'h011, 9'h15A, 9'h022, 9'h0A5, 9'h15A, 9'h000};

  initial begin
    logic [15:0] d;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      check("R1 reg after reset", d, 16'h0000);
    end
    check("R1 irq", {15'd0, irq}, 16'h0000);
    check("R1 ram_we/tx_load", {14'd0, ram_we, tx_load}, 16'h0000);

    // R11 disabled channels ignore strobes
    rx_send(8'h99);
    tx_pulse();
    check("R11 rx write while off", 16'(wr_count), 16'd0);
    check("R11 tx load while off", 16'(tx_count), 16'd0);

    // R9 byte lanes
    wr(3'd0, 2'b01, 16'hFF02);
    rd(3'd0, d);
    check("R9 low lane only", d, 16'h0002);
    wr(3'd0, 2'b10, 16'h02FF);
    rd(3'd0, d);
    check("R9 high lane only", d, 16'h0202);
    wr(3'd0, 2'b11, 16'h0000);

    // receive table, buffer straddles FFh
    wr(3'd5, 2'b01, 16'h005A);
    rd(3'd5, d);
    check("R6 match reg", d, 16'h005A);
    wr(3'd3, 2'b01, 16'h00FD);
    wr(3'd4, 2'b01, 16'h0006);
    wr(3'd0, 2'b01, 16'h0007);
    for (int i = 0; i < 6; i++) begin
      automatic logic [7:0] b = VEC[i][7:0];
      automatic logic       m = VEC[i][8];
      rx_send(b);
      @(negedge clk);
      check("R2/R10 stored byte", {8'd0, mem[8'(8'hFD + i)]}, {8'd0, b});
      rd(3'd0, d);
      check("R6 match flag", {15'd0, d[5]}, {15'd0, m});
      check("R8 irq", {15'd0, irq}, {15'd0, (m || i == 5)});
      if (m) begin
        wr(3'd0, 2'b01, 16'h0027);
        rd(3'd0, d);
        check("R7 match cleared", {15'd0, d[5]}, 16'h0000);
      end
    end
    rd(3'd3, d);
    check("R10 rx pointer wrapped", d, 16'h0003);
    rd(3'd4, d);
    check("R2 rx count", d, 16'h0000);
    rd(3'd0, d);
    check("R5 rx stopped", d, 16'h0016);
    rx_send(8'h33);
    check("R5 rx ignored after end", 16'(wr_count), 16'd6);
    wr(3'd0, 2'b01, 16'h0010);
    rd(3'd0, d);
    check("R7 done cleared", d, 16'h0000);
    check("R8 irq low", {15'd0, irq}, 16'h0000);

    // transmit
    mem[8'h40] = 8'h81; mem[8'h41] = 8'h82; mem[8'h42] = 8'h83;
    wr(3'd1, 2'b01, 16'h0040);
    wr(3'd2, 2'b01, 16'h0003);
    wr(3'd0, 2'b10, 16'h0300);
    for (int k = 0; k < 3; k++) begin
      tx_pulse();
      check("R3 tx load count", 16'(tx_count), 16'(k + 1));
      check("R3 tx byte", {8'd0, last_tx}, {8'd0, 8'(8'h81 + k)});
    end
    rd(3'd1, d);
    check("R3 tx pointer", d, 16'h0043);
    rd(3'd2, d);
    check("R3 tx count", d, 16'h0000);
    rd(3'd0, d);
    check("R5 tx stopped", d, 16'h1200);
    check("R8 irq tx done", {15'd0, irq}, 16'h0001);
    tx_pulse();
    check("R5 tx ignored after end", 16'(tx_count), 16'd3);
    wr(3'd0, 2'b10, 16'h1000);

    // R4 same-cycle contention
    mem[8'h50] = 8'hC3;
    wr(3'd1, 2'b01, 16'h0050);
    wr(3'd2, 2'b01, 16'h0001);
    wr(3'd3, 2'b01, 16'h0060);
    wr(3'd4, 2'b01, 16'h0001);
    wr(3'd0, 2'b11, 16'h0301);
    @(negedge clk);
    tx_free = 1'b1;
    @(negedge clk);
    tx_free = 1'b0; rx_valid = 1'b1; rx_data = 8'h7E;
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (4) @(negedge clk);
    check("R4 rx byte kept", {8'd0, mem[8'h60]}, 16'h007E);
    check("R4 tx byte", {8'd0, last_tx}, 16'h00C3);
    check("R4 tx count", 16'(tx_count), 16'd4);
    check("R4 tx delayed by one", 16'(tx_cyc - wr_cyc), 16'd2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule